// File: doc/BRIEF.md
# Nibble-to-Byte Handshake Bridge

This bridge takes a sender's narrow data path, one nibble per transfer, and hands a receiver whole bytes. Each nibble comes with a strobe. The strobe may stay high for any number of clock cycles, and a long strobe still counts as one nibble. The first nibble of a pair becomes the low half of the byte and the second becomes the high half. When both halves are in, the bridge loads its output register and raises a valid flag for one clock cycle.

An eight-state controller sequences the transfer. For each nibble there is a wait state, a capture state and a release state. The release state holds until the strobe drops, so one strobe can never be taken as two nibbles. Two more states then publish the byte. The datapath is two nibble registers and an output register, loaded by three enables from the controller. The receiver has no way to stall the bridge.

Top module: `nibble_byte_bridge`

## Requirements
- R1: While rst_ni is low, and at the first clock after it rises, byte_vld_o is 0 and byte_o is 0.
- R2: The assembled byte is `{second nibble, first nibble}`: the first nibble of a pair fills bits [3:0] and the second fills bits [7:4].
- R3: A nibble is taken from nib_i at the second rising clock edge after the edge that first samples nib_stb_i high. The sender must hold nib_i valid until that edge; later values of nib_i have no effect.
- R4: A strobe that stays high for many cycles is counted as one nibble. Once a nibble is captured, the next nibble is accepted only after a clock edge has sampled nib_stb_i low.
- R5: byte_vld_o is high for exactly one clock cycle per assembled byte. byte_o holds the new byte during that cycle.
- R6: byte_o keeps the last assembled byte until the next byte is published.
- R7: byte_vld_o rises at the second rising edge after the edge that samples nib_stb_i low at the end of the second nibble.
- R8: Asserting rst_ni in the middle of a pair discards the partial nibble. The next two strobes form a fresh pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by all registers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nib_i | input | NIB_W | Nibble from the sender |
| nib_stb_i | input | 1 | Sender strobe, one pulse of any length per nibble |
| byte_o | output | 2*NIB_W | Assembled byte, registered |
| byte_vld_o | output | 1 | One-cycle flag marking a newly published byte |

## Verification
The bound checker watches the output on every cycle. It checks that the valid flag never lasts two cycles, that byte_o changes only while the flag is high, and that every new flag is preceded, two edges earlier, by a sampled low strobe. The outputs are also checked during reset.

Byte ordering, the exact capture edge, the counting of long strobes and the recovery after a mid-pair reset cannot be seen from one cycle. The bench shows them by sweeping all 256 byte values under varied strobe lengths and gaps. It replaces nib_i with junk once the capture edge has passed.

// File: rtl/nbb_pkg.sv
package nbb_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_LO,
    ST_TAKE_LO,
    ST_END_LO,
    ST_WAIT_HI,
    ST_TAKE_HI,
    ST_END_HI,
    ST_SEND,
    ST_DONE
  } nbb_state_e;

  localparam int unsigned HALVES = 2;
endpackage

// File: rtl/nbb_ctrl.sv
module nbb_ctrl
  import nbb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  output logic lo_ld_o,
  output logic hi_ld_o,
  output logic out_ld_o
);
  nbb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT_LO: if (stb_i)  state_d = ST_TAKE_LO;
      ST_TAKE_LO:             state_d = ST_END_LO;
      ST_END_LO:  if (!stb_i) state_d = ST_WAIT_HI;
      ST_WAIT_HI: if (stb_i)  state_d = ST_TAKE_HI;
      ST_TAKE_HI:             state_d = ST_END_HI;
      ST_END_HI:  if (!stb_i) state_d = ST_SEND;
      ST_SEND:                state_d = ST_DONE;
      ST_DONE:                state_d = ST_WAIT_LO;
      default:                state_d = ST_WAIT_LO;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_WAIT_LO;
    else         state_q <= state_d;
  end

  assign lo_ld_o  = (state_q == ST_TAKE_LO);
  assign hi_ld_o  = (state_q == ST_TAKE_HI);
  assign out_ld_o = (state_q == ST_SEND);
endmodule

// File: rtl/nbb_nib_reg.sv
module nbb_nib_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end
endmodule

// File: rtl/nbb_datapath.sv
module nbb_datapath
  import nbb_pkg::*;
#(
  parameter  int unsigned NIB_W  = 4,
  localparam int unsigned BYTE_W = HALVES * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              lo_ld_i,
  input  logic              hi_ld_i,
  input  logic              out_ld_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              vld_o
);
  logic [HALVES-1:0] half_ld;
  logic [BYTE_W-1:0] halves;

  assign half_ld = {hi_ld_i, lo_ld_i};

  // half 0 holds the first nibble, half 1 the second
  for (genvar g = 0; g < HALVES; g++) begin : g_half
    nbb_nib_reg #(.W(NIB_W)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ld_i  (half_ld[g]),
      .d_i   (nib_i),
      .q_o   (halves[g*NIB_W +: NIB_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= out_ld_i;
      if (out_ld_i) byte_o <= halves;
    end
  end
endmodule

// File: rtl/nibble_byte_bridge.sv
module nibble_byte_bridge
  import nbb_pkg::*;
#(
  parameter  int unsigned NIB_W  = 4,
  localparam int unsigned BYTE_W = HALVES * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              nib_stb_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o
);
  logic lo_ld, hi_ld, out_ld;

  nbb_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (nib_stb_i),
    .lo_ld_o (lo_ld),
    .hi_ld_o (hi_ld),
    .out_ld_o(out_ld)
  );

  nbb_datapath #(.NIB_W(NIB_W)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nib_i   (nib_i),
    .lo_ld_i (lo_ld),
    .hi_ld_i (hi_ld),
    .out_ld_i(out_ld),
    .byte_o  (byte_o),
    .vld_o   (byte_vld_o)
  );
endmodule

// File: rtl/nbb_bridge_chk.sv
module nbb_bridge_chk #(
  parameter int unsigned NIB_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               nib_stb_i,
  input logic [2*NIB_W-1:0] byte_o,
  input logic               byte_vld_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!byte_vld_o && byte_o == '0)
        else $error("outputs not cleared in reset");
    end
  end

  // R5
  vld_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);

  // R6
  byte_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_o |-> $stable(byte_o));

  // R7
  release_before_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byte_vld_o) |-> !$past(nib_stb_i, 2));
endmodule

bind nibble_byte_bridge nbb_bridge_chk #(.NIB_W(NIB_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .nib_stb_i (nib_stb_i),
  .byte_o    (byte_o),
  .byte_vld_o(byte_vld_o)
);

// File: tb/tb_nibble_byte_bridge.sv
`timescale 1ns/1ps
module tb_nibble_byte_bridge;
  localparam int NW = 4;
  localparam int BW = 2 * NW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NW-1:0] nib_i = '0;
  logic          nib_stb_i = 1'b0;
  logic [BW-1:0] byte_o;
  logic          byte_vld_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  nibble_byte_bridge #(.NIB_W(NW)) dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nib_i     (nib_i),
    .nib_stb_i (nib_stb_i),
    .byte_o    (byte_o),
    .byte_vld_o(byte_vld_o)
  );

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // strobe held len cycles; nib_i replaced by junk after the capture edge (R3)
  task automatic pulse(input logic [NW-1:0] v, input int len);
    nib_i = v;
    nib_stb_i = 1'b1;
    for (int t = 1; t <= ((len > 2) ? len : 2); t++) begin
      @(negedge clk_i);
      if (t == len) nib_stb_i = 1'b0;
      if (t == 2)   nib_i = ~v;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // sends a byte; checks latency, value, pulse width and hold
  task automatic send_byte(input logic [BW-1:0] b, input int l1, input int l2,
                           input int gap, input logic [BW-1:0] prev);
    int n;
    pulse(b[NW-1:0], l1);
    check("R6 hold during first nibble", byte_o, prev);
    idle(gap);
    pulse(b[BW-1:NW], l2);
    n = 0;
    while (!byte_vld_o && n < 12) begin
      check("R6 hold before publish", byte_o, prev);
      @(negedge clk_i);
      n++;
    end
    check("R7 publish latency", n, 2);
    check("R2 R3 R4 assembled byte", byte_o, b);
    @(negedge clk_i);
    check("R5 vld single cycle", byte_vld_o, 1'b0);
    check("R6 byte held after publish", byte_o, b);
  endtask

  initial begin
    logic [BW-1:0] prev;
    @(negedge clk_i);
    check("R1 vld in reset", byte_vld_o, 1'b0);
    check("R1 byte in reset", byte_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 vld after reset", byte_vld_o, 1'b0);
    check("R1 byte after reset", byte_o, '0);

    // near-exhaustive sweep: every byte, varied strobe lengths and gaps
    prev = '0;
    for (int i = 0; i < 256; i++) begin
      send_byte(BW'(i), 1 + (i % 5), 1 + ((i / 5) % 6), 1 + (i % 3), prev);
      prev = BW'(i);
      idle(i % 2);
    end

    // very long strobes still count once (R4)
    send_byte(8'hC3, 20, 17, 2, prev);
    prev = 8'hC3;

    // R8: reset after the first nibble discards it
    pulse(4'hA, 2);
    idle(1);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R8 byte cleared by reset", byte_o, '0);
    check("R8 vld cleared by reset", byte_vld_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    send_byte(8'h5E, 3, 1, 1, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule